// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the two timing strobes a UART needs from its peripheral clock. The first is a one-cycle sample strobe at the oversampling rate. The second is a one-cycle bit strobe at the line bit rate.

The rate is set by four inputs:
- a 16-bit integer divisor, presented as a low byte and a high byte;
- a fractional prescaler, given as a multiplier and an adder, that stretches the clock by the factor (1 + adder/multiplier);
- an oversampling ratio, given as an integer part plus a fraction in eighths.

The generator needs no divider hardware. A modulo accumulator gates the clock down to the prescaled rate, and a reloading down-counter divides that rate by the integer divisor. An accumulator in eighths then turns sample strobes into bit strobes. It keeps the remainder, so the average bit period matches the fractional ratio.

Any change to the rate settings restarts every counter, so the new rate takes effect from a known phase. The settings are level inputs, normally driven by register flops elsewhere.

Top module: `frac_baud_gen`

## Requirements
- R1: While the reset input is low, and for the synchronising cycles after it rises, both strobes stay low.
- R2: Over a long window, the bit strobe rate is f_clk / (R × D × (1 + A/M)). Here D is the divisor ({hi,lo}), A is the adder, M is the multiplier and R = I + 1 + F/8, with I the 4-bit integer part and F the 2-bit fraction. The measured count lies within ±2 of that value.
- R3: With a valid fractional setting (1 ≤ M ≤ 15 and 1 ≤ A < M), an accumulator adds M every clock. It gives a prescale enable each time its sum reaches M + A, and subtracts M + A when it does. Over L clocks the number of enables is floor(L·M/(M+A)) ± 1.
- R4: With an adder value of 0, the prescaler gives an enable on every clock.
- R5: Out-of-range fractional settings (M = 0, or A ≥ M) also give an enable on every clock.
- R6: A divisor of 0 behaves exactly like a divisor of 1. With D ≤ 1 and the prescaler in bypass, the sample strobe is high on every cycle.
- R7: The sample strobe fires once per D prescale enables, one clock after the enable that completes the count. It is never high in the cycle after a clock with no enable.
- R8: Each sample strobe adds 8 to a counter. When the counter reaches 8·(I+1)+F, the bit strobe fires one clock later and the remainder is kept. A bit strobe is always preceded by a sample strobe in the cycle before it.
- R9: Any change to the divisor, fractional or oversampling inputs clears all counters. Both strobes are low in the cycle after the change, and the sample strobe resumes from a fresh divisor count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_lo_i | input | 8 | Integer divisor, low byte |
| div_hi_i | input | 8 | Integer divisor, high byte |
| frac_add_i | input | 4 | Fractional prescaler adder (A) |
| frac_mul_i | input | 4 | Fractional prescaler multiplier (M) |
| os_int_i | input | 4 | Oversampling ratio integer part minus one (I) |
| os_frac_i | input | 2 | Oversampling ratio fraction in eighths (F) |
| sample_tick_o | output | 1 | One-cycle oversampling strobe |
| bit_tick_o | output | 1 | One-cycle bit-rate strobe |

## Verification
Long windows are run with several kinds of setting:
- Bypassed prescaler with a unit divisor, which isolates the oversampling counter.
- Valid fractional pairs at both small and extreme M/A values, which isolate the prescale accumulator.
- Adder-zero and out-of-range pairs, which must match the bypassed counts exactly.
- Divisors of 0, small values and values above 255, which tell apart a correct reload from off-by-one reloads and from a missing high byte.

Oversampling ratios from the minimum of 8/8 to the maximum of 131/8, with non-zero fractions, show whether the remainder is kept. A rate change made while the generator is running checks the one-cycle gap and the restart.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Sample strobes per oversampling unit are counted in eighths
  localparam int unsigned OS_STEP   = 8;
  localparam int unsigned OS_STEP_W = 3;
  localparam int unsigned DEF_DIV_W = 16;
  localparam int unsigned DEF_FR_W  = 4;
  localparam int unsigned DEF_OSI_W = 4;
  localparam int unsigned DEF_OSF_W = 2;
endpackage

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int unsigned FR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            byp_i,
  input  logic [FR_W-1:0] mul_i,
  input  logic [FR_W-1:0] add_i,
  output logic            en_o
);
  localparam int unsigned AW = FR_W + 2;

  logic [AW-1:0] acc_q, acc_d, acc_sum, acc_lim;

  assign acc_sum = acc_q + AW'(mul_i);
  assign acc_lim = AW'(mul_i) + AW'(add_i);

  always_comb begin
    acc_d = acc_q;
    en_o  = 1'b0;
    if (clr_i) begin
      acc_d = '0;
    end else if (byp_i) begin
      acc_d = '0;
      en_o  = 1'b1;
    end else if (acc_sum >= acc_lim) begin
      acc_d = acc_sum - acc_lim;
      en_o  = 1'b1;
    end else begin
      acc_d = acc_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/fbg_divcnt.sv
module fbg_divcnt #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, reload;
  logic             tick_d;

  // A divisor of zero reloads like a divisor of one
  assign reload = (div_i == '0) ? '0 : div_i - DIV_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (clr_i) begin
      cnt_d = reload;
    end else if (en_i) begin
      if (cnt_q == '0) begin
        cnt_d  = reload;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_o <= tick_d;
    end
  end
endmodule

// File: rtl/fbg_bitcnt.sv
module fbg_bitcnt
  import fbg_pkg::*;
#(
  parameter int unsigned OSI_W = 4,
  parameter int unsigned OSF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic [OSI_W-1:0] os_int_i,
  input  logic [OSF_W-1:0] os_frac_i,
  output logic             tick_o
);
  localparam int unsigned TW = OSI_W + OS_STEP_W + 1;

  logic [TW-1:0] acc_q, acc_d, thr, acc_step;
  logic          tick_d;

  // threshold = step * (int + 1) + frac, all in eighths
  assign thr      = ((TW'(os_int_i) + TW'(1)) << OS_STEP_W) + TW'(os_frac_i);
  assign acc_step = acc_q + TW'(OS_STEP);

  always_comb begin
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (clr_i) begin
      acc_d = '0;
    end else if (smp_i) begin
      if (acc_step >= thr) begin
        acc_d  = acc_step - thr;
        tick_d = 1'b1;
      end else begin
        acc_d = acc_step;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_o <= tick_d;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W,
  parameter int unsigned FR_W  = DEF_FR_W,
  parameter int unsigned OSI_W = DEF_OSI_W,
  parameter int unsigned OSF_W = DEF_OSF_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_W/2-1:0]   div_lo_i,
  input  logic [DIV_W/2-1:0]   div_hi_i,
  input  logic [FR_W-1:0]      frac_add_i,
  input  logic [FR_W-1:0]      frac_mul_i,
  input  logic [OSI_W-1:0]     os_int_i,
  input  logic [OSF_W-1:0]     os_frac_i,
  output logic                 sample_tick_o,
  output logic                 bit_tick_o
);
  localparam int unsigned CFG_W = DIV_W + 2 * FR_W + OSI_W + OSF_W;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             restart;
  logic             frac_byp;
  logic             pre_en;
  logic [DIV_W-1:0] div_val;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign div_val = {div_hi_i, div_lo_i};
  assign cfg_now = {div_val, frac_add_i, frac_mul_i, os_int_i, os_frac_i};
  assign restart = (cfg_now != cfg_q);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) cfg_q <= '0;
    else          cfg_q <= cfg_now;
  end

  assign frac_byp = (frac_mul_i == '0) || (frac_add_i == '0) ||
                    (frac_add_i >= frac_mul_i);

  fbg_prescale #(.FR_W(FR_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .clr_i (restart),
    .byp_i (frac_byp),
    .mul_i (frac_mul_i),
    .add_i (frac_add_i),
    .en_o  (pre_en)
  );

  fbg_divcnt #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .clr_i (restart),
    .en_i  (pre_en),
    .div_i (div_val),
    .tick_o(sample_tick_o)
  );

  fbg_bitcnt #(.OSI_W(OSI_W), .OSF_W(OSF_W)) u_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .clr_i    (restart),
    .smp_i    (sample_tick_o),
    .os_int_i (os_int_i),
    .os_frac_i(os_frac_i),
    .tick_o   (bit_tick_o)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             restart,
  input logic             frac_byp,
  input logic             pre_en,
  input logic [DIV_W-1:0] div_val,
  input logic             sample_tick,
  input logic             bit_tick
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_n |-> (!sample_tick && !bit_tick));

  // R8
  bit_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    bit_tick |-> $past(sample_tick));

  // R9
  restart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    restart |=> (!sample_tick && !bit_tick));

  // R7
  no_enable_no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pre_en |=> !sample_tick);

  // R4 R5
  bypass_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (frac_byp && !restart) |-> pre_en);

  // R6
  unit_divisor_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (div_val <= DIV_W'(1) && pre_en && !restart) |=> sample_tick);
endmodule

bind frac_baud_gen fbg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_s),
  .restart    (restart),
  .frac_byp   (frac_byp),
  .pre_en     (pre_en),
  .div_val    (div_val),
  .sample_tick(sample_tick_o),
  .bit_tick   (bit_tick_o)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/100ps
module sim_frac_baud_gen;
  typedef struct {
    string tag;
    int    exp_s;
    int    exp_b;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lo = 8'd0, hi = 8'd0;
  logic [3:0] fadd = 4'd0, fmul = 4'd0, oint = 4'd0;
  logic [1:0] ofrac = 2'd0;
  logic       smp, bitt;
  logic       win = 1'b0;
  exp_t       sb_q[$];
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_lo_i(lo), .div_hi_i(hi),
    .frac_add_i(fadd), .frac_mul_i(fmul), .os_int_i(oint), .os_frac_i(ofrac),
    .sample_tick_o(smp), .bit_tick_o(bitt)
  );

  task automatic check(input string req, input int act, input int exp, input int tol);
    n_chk++;
    if (act < exp - tol || act > exp + tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  // Expected counts from the rate formula, computed from the raw fields
  task automatic run_cfg(input string tag, input int dlo, input int dhi, input int m,
                         input int a, input int oi, input int of, input int len);
    int d, e, s, t;
    exp_t it;
    @(negedge clk);
    lo = 8'(dlo); hi = 8'(dhi); fmul = 4'(m); fadd = 4'(a);
    oint = 4'(oi); ofrac = 2'(of);
    repeat (5) @(negedge clk);
    d = dhi * 256 + dlo;
    if (d == 0) d = 1;
    if (m == 0 || a == 0 || a >= m) e = len;
    else e = (len * m) / (m + a);
    s = e / d;
    t = 8 * (oi + 1) + of;
    it.tag = tag; it.exp_s = s; it.exp_b = (8 * s) / t;
    sb_q.push_back(it);
    win = 1'b1;
    repeat (len + 1) @(negedge clk);
    win = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: counts strobes over each window and scores against the queue
  initial begin
    forever begin
      int sc, bc;
      exp_t it;
      @(posedge win);
      sc = 0; bc = 0;
      forever begin
        @(negedge clk); #1;
        if (!win) break;
        sc += int'(smp);
        bc += int'(bitt);
      end
      if (sb_q.size() == 0) begin
        check("scoreboard empty", 1, 0, 0);
      end else begin
        it = sb_q.pop_front();
        check({it.tag, " sample count"}, sc, it.exp_s, 1);
        check({it.tag, " bit count R2"}, bc, it.exp_b, 2);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: quiet while reset is held
    repeat (4) begin
      @(negedge clk); #1;
      check("R1 sample in reset", int'(smp), 0, 0);
      check("R1 bit in reset", int'(bitt), 0, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 sample after release", int'(smp), 0, 0);

    run_cfg("R6 R4 unit divisor min ratio", 1, 0, 0, 0, 0, 0, 400);
    // R9: rate change while running gives a one-cycle gap
    @(negedge clk); oint = 4'd2;
    @(negedge clk); #1;
    check("R9 gap after change", int'(smp), 0, 0);
    check("R9 no bit after change", int'(bitt), 0, 0);
    @(negedge clk); #1;
    check("R9 resume after change", int'(smp), 1, 0);

    run_cfg("R6 zero divisor max ratio", 0, 0, 0, 0, 15, 3, 2620);
    run_cfg("R3 R7 frac 4/1 div 3", 3, 0, 4, 1, 15, 0, 6000);
    run_cfg("R4 adder zero div 2", 2, 0, 7, 0, 9, 2, 4000);
    run_cfg("R5 adder equals mul", 4, 0, 5, 5, 3, 1, 4000);
    run_cfg("R5 mul zero", 5, 0, 0, 3, 7, 3, 5000);
    run_cfg("R3 frac 15/14 div 2", 2, 0, 15, 14, 1, 1, 5800);
    run_cfg("R7 high byte divisor", 4, 1, 0, 0, 0, 0, 26000);
    run_cfg("R3 R8 frac 13/2 div 7", 7, 0, 13, 2, 11, 2, 10500);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule